// File: doc/BRIEF.md
# Quad-Redundant Serial Stream Voter

Four redundant processing copies produce the same output words and each writes them into its own parallel-in, serial-out FIFO. A single shared start strobe from the voter side releases one word from all four FIFOs at once, so the four synchronous serial lines shift in lock step, most significant bit first, one bit on each clock-enable tick. A four-input bitwise voter combines the lines into one output stream.

When one line disagrees with the other three, the voter drops it, emits the majority value and counts the event both in a corrected-error total and against the copy that dissented, so a supervisory controller can read them for telemetry and tell which copy is faulty. A two-against-two split cannot be corrected: the voter emits the bit of the pair that contains copy 0 and raises a sticky flag. A start request that finds the FIFOs holding unequal numbers of words raises a sticky synchronisation-fault flag.

Top module: `qmr_stream_voter`

## Requirements
- R1: After synchronous active-low reset, `ser_valid`, `ser_out`, `busy`, `corr_cnt`, every field of `dissent_cnt`, `uncorr_err` and `sync_fault` are 0, and all FIFOs are empty.
- R2: A high `wr_en[i]` stores `wr_data[8*i+7:8*i]` into FIFO i; each FIFO holds 4 words in arrival order, and a write into a full FIFO is dropped.
- R3: `start` is accepted only when the block is idle and all four FIFOs hold at least one word; otherwise it is ignored and no bit leaves.
- R4: After an accepted start, each word leaves most significant bit first, one bit per `bit_tick`; `ser_valid` is high for one cycle in the cycle after each tick, exactly 8 times, and then the block is idle. `bit_tick` while idle has no effect.
- R5: When all four lines agree, `ser_out` equals that bit and no counter or flag changes.
- R6: When exactly one line differs, `ser_out` is the value of the other three, `corr_cnt` increments by one and the dissenting copy's field `dissent_cnt[16*i+15:16*i]` increments by one.
- R7: On a two-against-two split, `ser_out` equals copy 0's bit, `uncorr_err` becomes 1 and stays 1 until reset, and no counter changes.
- R8: `corr_cnt` and every `dissent_cnt` field saturate at 65535.
- R9: A start request while idle with unequal FIFO word counts sets `sync_fault`, which stays 1 until reset; such a start is still accepted if all four FIFOs are non-empty.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| wr_en | input | 4 | Write strobe, one per copy |
| wr_data | input | 32 | Write words, copy i in bits 8*i+7:8*i |
| start | input | 1 | Shared start strobe for all four FIFOs |
| bit_tick | input | 1 | Clock enable for one serial bit |
| ser_out | output | 1 | Voted serial bit |
| ser_valid | output | 1 | One-cycle qualifier for `ser_out` |
| busy | output | 1 | A word is being shifted |
| corr_cnt | output | 16 | Saturating count of corrected bits |
| dissent_cnt | output | 64 | Saturating per-copy disagreement counts, copy i in bits 16*i+15:16*i |
| uncorr_err | output | 1 | Sticky two-against-two flag |
| sync_fault | output | 1 | Sticky unequal-FIFO-level flag |

## Verification
The assertions assume a well-formed drive: `start` and `bit_tick` are single-cycle strobes that are only meaningful in the clock domain of the block, and writers never rely on a write landing in a full FIFO. The stimulus writes all four copies in the same cycle for normal traffic, so the FIFO levels stay equal except in the directed cases built to break that, and it corrupts copies with random bit masks that mix clean, single-dissent and tied bits within one word. A long run with one copy inverted drives both the shared and the per-copy counters into saturation.

// File: rtl/qmr_pkg.sv
// Package: shared constants and the four-way bit vote used by the voter.
// Assumes exactly four redundant copies.
package qmr_pkg;

    localparam int NCOPY = 4;

    typedef struct packed {
        logic       out_bit;   // value to emit
        logic       single;    // exactly one line dissents
        logic       tie;       // two against two
        logic [3:0] odd_vec;   // one-hot dissenting copy when single
    } vote_t;

    // Count ones on the four lines.
    function automatic logic [2:0] ones4(input logic [3:0] v);
        logic [2:0] n;
        n = 3'd0;
        for (int i = 0; i < NCOPY; i++) begin
            n = n + {2'b00, v[i]};
        end
        return n;
    endfunction

    // Majority vote with tie resolved toward copy 0.
    function automatic vote_t vote4(input logic [3:0] v);
        vote_t      r;
        logic [2:0] n;
        logic       maj;
        n         = ones4(v);
        maj       = (n >= 3'd3);
        r.tie     = (n == 3'd2);
        r.single  = (n == 3'd1) || (n == 3'd3);
        r.out_bit = r.tie ? v[0] : maj;
        r.odd_vec = r.single ? (v ^ {4{maj}}) : 4'b0000;
        return r;
    endfunction

endpackage

// File: rtl/qmr_piso_fifo.sv
// Parallel-in serial-out FIFO for one redundant copy.
// Words are queued in a small circular store; 'load' pops the oldest word
// into a shift register whose MSB drives the serial line, 'shift' moves it
// left by one. Assumes DEPTH is a power of two. Writes into a full store
// are dropped.
module qmr_piso_fifo #(
    parameter int WORD_W = 8,
    parameter int DEPTH  = 4,
    localparam int PTR_W = $clog2(DEPTH),
    localparam int LVL_W = $clog2(DEPTH + 1)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_en,
    input  logic [WORD_W-1:0] wr_data,
    input  logic              load,
    input  logic              shift,
    output logic              ser_bit,
    output logic              empty,
    output logic [LVL_W-1:0]  level
);

    logic [WORD_W-1:0] mem [DEPTH];
    logic [PTR_W-1:0]  wr_ptr, rd_ptr;
    logic [WORD_W-1:0] shreg;
    logic              do_wr, do_rd;

    assign do_wr   = wr_en && (level != LVL_W'(DEPTH));
    assign do_rd   = load && (level != '0);
    assign empty   = (level == '0);
    assign ser_bit = shreg[WORD_W-1];

    // Storage array: written only on an accepted write.
    always_ff @(posedge clk) begin
        if (do_wr) begin
            mem[wr_ptr] <= wr_data;
        end
    end

    // Pointers, fill level and shift register.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            wr_ptr <= '0;
            rd_ptr <= '0;
            level  <= '0;
            shreg  <= '0;
        end else begin
            if (do_wr) begin
                wr_ptr <= wr_ptr + 1'b1;
            end
            if (do_rd) begin
                shreg  <= mem[rd_ptr];
                rd_ptr <= rd_ptr + 1'b1;
            end else if (shift) begin
                shreg <= {shreg[WORD_W-2:0], 1'b0};
            end
            case ({do_wr, do_rd})
                2'b10:   level <= level + 1'b1;
                2'b01:   level <= level - 1'b1;
                default: level <= level;
            endcase
        end
    end

    AST_NO_OVERFLOW: assert property (@(posedge clk) disable iff (!rst_n)
        level <= LVL_W'(DEPTH)) else $error("fifo level above depth"); // R2
    AST_FULL_HOLDS: assert property (@(posedge clk) disable iff (!rst_n)
        (level == LVL_W'(DEPTH) && !load) |=> level == LVL_W'(DEPTH)) else $error("full fifo lost a word"); // R2

endmodule

// File: rtl/qmr_start_ctrl.sv
// Shared start control: accepts a start only when idle and every FIFO holds a
// word, then qualifies WORD_W bit ticks as shift/sample strobes. Flags a
// start request that sees unequal FIFO levels. Assumes single-cycle strobes.
module qmr_start_ctrl #(
    parameter int WORD_W = 8,
    localparam int IDX_W = $clog2(WORD_W)
) (
    input  logic clk,
    input  logic rst_n,
    input  logic start,
    input  logic bit_tick,
    input  logic all_ready,
    input  logic levels_equal,
    output logic load,
    output logic sample,
    output logic busy,
    output logic sync_fault
);

    logic [IDX_W-1:0] bit_idx;

    assign load   = start && !busy && all_ready;
    assign sample = busy && bit_tick;

    // Word window: opens on an accepted start, closes after the last bit.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            busy    <= 1'b0;
            bit_idx <= '0;
        end else if (load) begin
            busy    <= 1'b1;
            bit_idx <= '0;
        end else if (sample) begin
            bit_idx <= bit_idx + 1'b1;
            if (bit_idx == IDX_W'(WORD_W - 1)) begin
                busy <= 1'b0;
            end
        end
    end

    // Sticky synchronisation fault on a start request with unequal levels.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            sync_fault <= 1'b0;
        end else if (start && !busy && !levels_equal) begin
            sync_fault <= 1'b1;
        end
    end

    AST_BUSY_FROM_START: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(busy) |-> $past(start && all_ready)) else $error("busy without start"); // R3
    AST_IDLE_INDEX: assert property (@(posedge clk) disable iff (!rst_n)
        !busy |-> bit_idx == '0) else $error("index moved while idle"); // R4
    AST_SYNC_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
        sync_fault |=> sync_fault) else $error("sync fault cleared"); // R9

endmodule

// File: rtl/qmr_bit_voter.sv
// Four-input bitwise voter with error accounting. On each sample it registers
// the voted bit, counts a single dissent against the total and the dissenting
// copy, and latches a sticky flag on a two-against-two split. All counters
// saturate. Assumes the four lines are aligned to the same bit.
module qmr_bit_voter
    import qmr_pkg::*;
#(
    parameter int CNT_W = 16
) (
    input  logic                   clk,
    input  logic                   rst_n,
    input  logic                   sample,
    input  logic [NCOPY-1:0]       lines,
    output logic                   ser_out,
    output logic                   ser_valid,
    output logic [CNT_W-1:0]       corr_cnt,
    output logic [NCOPY*CNT_W-1:0] dissent_cnt,
    output logic                   uncorr_err
);

    localparam logic [CNT_W-1:0] CNT_MAX = '1;

    vote_t vr;

    // Combinational vote of the current bit on all four lines.
    always_comb begin
        vr = vote4(lines);
    end

    // Output register and shared error state.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            ser_out    <= 1'b0;
            ser_valid  <= 1'b0;
            corr_cnt   <= '0;
            uncorr_err <= 1'b0;
        end else begin
            ser_valid <= sample;
            if (sample) begin
                ser_out <= vr.out_bit;
                if (vr.single && corr_cnt != CNT_MAX) begin
                    corr_cnt <= corr_cnt + 1'b1;
                end
                if (vr.tie) begin
                    uncorr_err <= 1'b1;
                end
            end
        end
    end

    for (genvar i = 0; i < NCOPY; i++) begin : g_dissent
        logic [CNT_W-1:0] cnt_q;
        // Per-copy disagreement counter.
        always_ff @(posedge clk) begin
            if (!rst_n) begin
                cnt_q <= '0;
            end else if (sample && vr.odd_vec[i] && cnt_q != CNT_MAX) begin
                cnt_q <= cnt_q + 1'b1;
            end
        end
        assign dissent_cnt[i*CNT_W +: CNT_W] = cnt_q;
    end

    AST_MAJORITY_ONE: assert property (@(posedge clk) disable iff (!rst_n)
        (sample && ones4(lines) >= 3'd3) |=> ser_out) else $error("majority one lost"); // R6
    AST_MAJORITY_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
        (sample && ones4(lines) <= 3'd1) |=> !ser_out) else $error("majority zero lost"); // R6
    AST_CORR_SAT: assert property (@(posedge clk) disable iff (!rst_n)
        corr_cnt == CNT_MAX |=> corr_cnt == CNT_MAX) else $error("counter wrapped"); // R8
    AST_UNCORR_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
        uncorr_err |=> uncorr_err) else $error("uncorrectable flag cleared"); // R7
    AST_CLEAN_NO_COUNT: assert property (@(posedge clk) disable iff (!rst_n)
        (sample && (lines == 4'b0000 || lines == 4'b1111)) |=> $stable(corr_cnt)) else $error("clean bit counted"); // R5

endmodule

// File: rtl/qmr_stream_voter.sv
// Top: four PISO FIFOs, one shared start control and one bitwise voter for a
// single output channel. Assumes start and bit_tick are synchronous
// single-cycle strobes.
module qmr_stream_voter
    import qmr_pkg::*;
#(
    parameter int WORD_W = 8,
    parameter int DEPTH  = 4,
    parameter int CNT_W  = 16,
    localparam int LVL_W = $clog2(DEPTH + 1)
) (
    input  logic                    clk,
    input  logic                    rst_n,
    input  logic [NCOPY-1:0]        wr_en,
    input  logic [NCOPY*WORD_W-1:0] wr_data,
    input  logic                    start,
    input  logic                    bit_tick,
    output logic                    ser_out,
    output logic                    ser_valid,
    output logic                    busy,
    output logic [CNT_W-1:0]        corr_cnt,
    output logic [NCOPY*CNT_W-1:0]  dissent_cnt,
    output logic                    uncorr_err,
    output logic                    sync_fault
);

    logic [NCOPY-1:0] lines;
    logic [NCOPY-1:0] empty_v;
    logic [LVL_W-1:0] level_v [NCOPY];
    logic             load, sample, all_ready, levels_equal;

    for (genvar i = 0; i < NCOPY; i++) begin : g_copy
        qmr_piso_fifo #(
            .WORD_W (WORD_W),
            .DEPTH  (DEPTH)
        ) u_fifo (
            .clk     (clk),
            .rst_n   (rst_n),
            .wr_en   (wr_en[i]),
            .wr_data (wr_data[i*WORD_W +: WORD_W]),
            .load    (load),
            .shift   (sample),
            .ser_bit (lines[i]),
            .empty   (empty_v[i]),
            .level   (level_v[i])
        );
    end

    // Readiness and level agreement across the four FIFOs.
    always_comb begin
        all_ready    = ~|empty_v;
        levels_equal = 1'b1;
        for (int i = 1; i < NCOPY; i++) begin
            if (level_v[i] != level_v[0]) begin
                levels_equal = 1'b0;
            end
        end
    end

    qmr_start_ctrl #(
        .WORD_W (WORD_W)
    ) u_ctrl (
        .clk          (clk),
        .rst_n        (rst_n),
        .start        (start),
        .bit_tick     (bit_tick),
        .all_ready    (all_ready),
        .levels_equal (levels_equal),
        .load         (load),
        .sample       (sample),
        .busy         (busy),
        .sync_fault   (sync_fault)
    );

    qmr_bit_voter #(
        .CNT_W (CNT_W)
    ) u_voter (
        .clk         (clk),
        .rst_n       (rst_n),
        .sample      (sample),
        .lines       (lines),
        .ser_out     (ser_out),
        .ser_valid   (ser_valid),
        .corr_cnt    (corr_cnt),
        .dissent_cnt (dissent_cnt),
        .uncorr_err  (uncorr_err)
    );

    AST_VALID_IN_WORD: assert property (@(posedge clk) disable iff (!rst_n)
        ser_valid |-> $past(busy && bit_tick)) else $error("valid outside a word"); // R4
    AST_NO_START_EMPTY: assert property (@(posedge clk) disable iff (!rst_n)
        (!busy && start && |empty_v) |=> !busy) else $error("start taken with empty fifo"); // R3

endmodule

// File: tb/tb_qmr_stream_voter.sv
module tb_qmr_stream_voter;

    localparam int W  = 8;
    localparam int CW = 16;

    logic          clk = 1'b0;
    logic          rst_n;
    logic [3:0]    wr_en;
    logic [31:0]   wr_data;
    logic          start;
    logic          bit_tick;
    logic          ser_out, ser_valid, busy, uncorr_err, sync_fault;
    logic [15:0]   corr_cnt;
    logic [63:0]   dissent_cnt;

    int checks = 0;
    int errors = 0;
    bit done   = 0;

    int exp_corr;
    int exp_dis [4];
    bit exp_uncorr;

    always #2 clk = ~clk;

    qmr_stream_voter dut (
        .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_data(wr_data),
        .start(start), .bit_tick(bit_tick), .ser_out(ser_out),
        .ser_valid(ser_valid), .busy(busy), .corr_cnt(corr_cnt),
        .dissent_cnt(dissent_cnt), .uncorr_err(uncorr_err), .sync_fault(sync_fault)
    );

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: actual %0h expected %0h", req, act, exp);
        end
    endtask

    function automatic int sat_inc(input int v);
        return (v >= 65535) ? 65535 : v + 1;
    endfunction

    // Expected voted bit for the four line values; updates the model state.
    function automatic bit model_bit(input bit [3:0] l);
        int n;
        bit maj;
        n = 0;
        for (int i = 0; i < 4; i++) n += l[i];
        maj = (n >= 3);
        if (n == 2) begin
            exp_uncorr = 1;
            return l[0];
        end
        if (n == 1 || n == 3) begin
            exp_corr = sat_inc(exp_corr);
            for (int i = 0; i < 4; i++)
                if (l[i] != maj) exp_dis[i] = sat_inc(exp_dis[i]);
        end
        return maj;
    endfunction

    task automatic do_reset();
        rst_n = 0; wr_en = 0; wr_data = 0; start = 0; bit_tick = 0;
        repeat (3) @(negedge clk);
        rst_n = 1;
        @(negedge clk);
        exp_corr = 0; exp_uncorr = 0;
        for (int i = 0; i < 4; i++) exp_dis[i] = 0;
    endtask

    task automatic write_words(input logic [3:0] mask, input logic [31:0] d);
        wr_en = mask; wr_data = d;
        @(negedge clk);
        wr_en = 0;
    endtask

    // Start plus eight ticks; with 'expect_out' the voted bits are checked.
    task automatic run_word(input logic [31:0] d, input bit expect_out, input bit check_bits);
        bit [3:0] l;
        bit       e;
        bit       bad;
        start = 1;
        @(negedge clk);
        start = 0;
        bit_tick = 1;
        bad = 0;
        for (int b = W - 1; b >= 0; b--) begin
            @(negedge clk);
            if (expect_out) begin
                for (int i = 0; i < 4; i++) l[i] = d[i*8 + b];
                e = model_bit(l);
                if (check_bits) begin
                    chk("R4 valid per tick", {31'd0, ser_valid}, 32'd1);
                    chk("R5/R6/R7 voted bit", {31'd0, ser_out}, {31'd0, e});
                end
            end else if (ser_valid) begin
                bad = 1;
            end
        end
        bit_tick = 0;
        if (!expect_out) chk("R3 start ignored, no output", {31'd0, bad}, 32'd0);
    endtask

    task automatic chk_counters(input string req);
        chk({req, " corr_cnt"}, {16'd0, corr_cnt}, exp_corr);
        for (int i = 0; i < 4; i++)
            chk({req, " dissent_cnt"}, {16'd0, dissent_cnt[i*CW +: CW]}, exp_dis[i]);
        chk({req, " uncorr_err"}, {31'd0, uncorr_err}, {31'd0, exp_uncorr});
    endtask

    initial begin
        logic [31:0] d;
        logic [7:0]  base, m1, m2;
        int          mode, k, p;
        void'($urandom(32'h5EED_0042));

        do_reset();
        // R1 reset state
        chk("R1 ser_valid", {31'd0, ser_valid}, 0);
        chk("R1 ser_out", {31'd0, ser_out}, 0);
        chk("R1 busy", {31'd0, busy}, 0);
        chk("R1 sync_fault", {31'd0, sync_fault}, 0);
        chk_counters("R1");

        // R4: ticks while idle produce nothing
        bit_tick = 1;
        begin
            bit seen = 0;
            repeat (5) begin @(negedge clk); if (ser_valid) seen = 1; end
            chk("R4 idle tick ignored", {31'd0, seen}, 0);
        end
        bit_tick = 0;

        // R3: start with empty FIFOs ignored
        run_word(32'd0, 0, 0);

        // R5 clean word
        d = {4{8'hA5}};
        write_words(4'hF, d);
        run_word(d, 1, 1);
        chk("R4 idle after word", {31'd0, busy}, 0);
        chk_counters("R5");

        // R6 single dissent on copy 2
        d = {8'h3C, 8'h3C ^ 8'h81, 8'h3C, 8'h3C};
        write_words(4'hF, d);
        run_word(d, 1, 1);
        chk_counters("R6");

        // R7 tie: copies 0,1 = FF, copies 2,3 = 00 -> FF
        d = {8'h00, 8'h00, 8'hFF, 8'hFF};
        write_words(4'hF, d);
        run_word(d, 1, 1);
        // R7 tie: copies 0,2 = 00, copies 1,3 = FF -> 00
        d = {8'hFF, 8'h00, 8'hFF, 8'h00};
        write_words(4'hF, d);
        run_word(d, 1, 1);
        chk_counters("R7");

        // Random traffic: clean, single dissent, tie, double masks
        for (int n = 0; n < 60; n++) begin
            base = 8'($urandom); m1 = 8'($urandom); m2 = 8'($urandom);
            mode = $urandom % 4;
            k = $urandom % 4;
            p = 1 + ($urandom % 3);
            for (int i = 0; i < 4; i++) d[i*8 +: 8] = base;
            case (mode)
                1: d[k*8 +: 8] = base ^ m1;
                2: for (int i = 1; i < 4; i++) if (i != p) d[i*8 +: 8] = base ^ m1;
                3: begin d[k*8 +: 8] = base ^ m1; d[((k+1)%4)*8 +: 8] = base ^ m2; end
                default: ;
            endcase
            write_words(4'hF, d);
            run_word(d, 1, 1);
        end
        chk_counters("R6 random");

        // R2: overflow drops fifth write, order preserved
        do_reset();
        for (int n = 0; n < 5; n++) write_words(4'hF, {4{8'(8'h10 + n)}});
        for (int n = 0; n < 4; n++) run_word({4{8'(8'h10 + n)}}, 1, 1);
        run_word(32'd0, 0, 0);   // R2 fifth word was dropped

        // R3/R9: one FIFO empty -> start ignored, sync fault latched
        do_reset();
        write_words(4'b0111, {4{8'h5A}});
        run_word(32'd0, 0, 0);
        chk("R9 sync_fault set", {31'd0, sync_fault}, 1);
        write_words(4'b1000, {4{8'h5A}});
        run_word({4{8'h5A}}, 1, 1);
        // R9: unequal but non-empty levels -> accepted, flag still set
        write_words(4'hF, {4{8'hC3}});
        write_words(4'b0001, {4{8'h77}});
        run_word({4{8'hC3}}, 1, 1);
        chk("R9 sync_fault sticky", {31'd0, sync_fault}, 1);

        // R8: saturation with copy 1 always inverted
        do_reset();
        for (int n = 0; n < 8200; n++) begin
            base = 8'(n);
            d = {base, base, ~base, base};
            write_words(4'hF, d);
            run_word(d, 1, 0);
        end
        chk("R8 corr_cnt saturated", {16'd0, corr_cnt}, 32'd65535);
        chk("R8 dissent_cnt copy1 saturated", {16'd0, dissent_cnt[CW +: CW]}, 32'd65535);
        chk("R8 dissent_cnt copy0", {16'd0, dissent_cnt[0 +: CW]}, 32'd0);

        done = 1;
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        repeat (195000) @(posedge clk);
        if (!done) begin
            checks++;
            errors++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end

endmodule